// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table held in memory. A requester presents the virtual address together with a user/kernel flag and a write flag. The walker reads one first-level descriptor. If that descriptor points to a second-level table, it reads one second-level descriptor as well. It then returns either the physical address with its cacheable and bufferable attributes, or a fault code. Memory is reached through a read port that has at most one read in flight.

Two configuration registers steer the walk. The table base register gives the 16 KB-aligned origin of the first-level table. The domain register holds sixteen 2-bit fields, and each field decides how one domain is treated: always fault, check the permission bits, or grant access without checking them.

The first-level table maps 1 MB sections directly. It can also point to a coarse second-level table, which maps 64 KB and 4 KB pages, or to a fine second-level table, which maps 1 KB pages. A 64 KB or 4 KB page is split into four quarters, and each quarter has its own permission field. The domain is always checked before the permission bits.

Top module: `mmu_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_rd_req` and `rsp_valid` are 0.
- R2: A request is taken only while `req_ready` is 1, and `req_ready` is 1 only when the walker is idle. Request inputs seen while a walk is running have no effect. The first read goes to {base[31:14], VA[31:20], 2'b00}. A read holds `mem_rd_req` and a stable `mem_rd_addr` until `mem_rd_ack`, and only one read is in flight at a time.
- R3: A first-level descriptor whose bits [1:0] are 00 ends the walk with fault code 1 (section translation). No second read is made.
- R4: A first-level descriptor with bits [1:0] = 10 is a section. It gives PA = {d[31:20], VA[19:0]}, cacheable = d[3], bufferable = d[2], permission = d[11:10] and domain = d[8:5].
- R5: A first-level descriptor with bits [1:0] = 01 selects a coarse table. The second read goes to {d[31:10], VA[19:12], 2'b00}, and the domain is d[8:5]. In the coarse table, type 01 is a 64 KB page with PA = {e[31:16], VA[15:0]} and permission field chosen by VA[15:14]. Type 10 is a 4 KB page with PA = {e[31:12], VA[11:0]} and permission field chosen by VA[11:10]. Field k sits at e[5+2k:4+2k].
- R6: A first-level descriptor with bits [1:0] = 11 selects a fine table. The second read goes to {d[31:12], VA[19:10], 2'b00}. Type 11 there is a 1 KB page with PA = {e[31:10], VA[9:0]} and permission field e[5:4]. For every page, cacheable = e[3] and bufferable = e[2].
- R7: Any of the following ends the walk with fault code 2 (page translation): second-level type 00, type 11 in a coarse table, or type 01 or 10 in a fine table.
- R8: Domain field 00 (no access) or 10 (reserved) gives fault code 3 (domain). This check wins over the permission check. Domain field 11 (manager) grants access whatever the permission bits say.
- R9: Domain field 01 (client) applies the permission field. 00 allows kernel reads only. 01 allows kernel read/write and gives the user nothing. 10 allows kernel read/write and user reads. 11 allows everything. A refused access gives fault code 4 (permission).
- R10: `rsp_valid` is high for exactly one cycle, and the walker is ready again in the next cycle. Fault code 0 means success. When the fault code is not 0, `rsp_pa`, `rsp_cacheable` and `rsp_bufferable` are 0.
- R11: `cfg_base_we` loads `cfg_wdata[31:14]` as the table base. `cfg_dac_we` loads all 32 bits as the domain register, with domain n held in bits [2n+1:2n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base_we | input | 1 | Write strobe for the table base |
| cfg_dac_we | input | 1 | Write strobe for the domain register |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker is idle and takes a request |
| req_va | input | 32 | Virtual address |
| req_user | input | 1 | 1 for a user access, 0 for a kernel access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| mem_rd_req | output | 1 | Descriptor read request |
| mem_rd_addr | output | 32 | Descriptor word address |
| mem_rd_ack | input | 1 | Read completes; data is valid this cycle |
| mem_rd_data | input | 32 | Descriptor read data |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_pa | output | 32 | Physical address |
| rsp_cacheable | output | 1 | Cacheable attribute |
| rsp_bufferable | output | 1 | Bufferable attribute |
| rsp_fault | output | 3 | 0 none, 1 section translation, 2 page translation, 3 domain, 4 permission |

## Verification
The assertions make three assumptions about the inputs. The memory side raises `mem_rd_ack` only while `mem_rd_req` is high, and it presents the descriptor in that same cycle. The configuration registers are written only between walks. A descriptor read always returns a defined word. The bench respects all three: its memory responder acks only a read it sees pending, after a random wait of zero to two cycles, and returns zero for any unwritten word. Configuration writes happen only while the walker is idle. Second-level tables are placed in the upper half of the address space, so a random second-level entry can never overwrite the first-level entry of the same walk.

// File: rtl/walk_pkg.sv
package walk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_L1   = 2'd1,
      ST_L2   = 2'd2,
      ST_DONE = 2'd3
   } walk_st_e;

   typedef enum logic [2:0] {
      FLT_NONE      = 3'd0,
      FLT_SECT_XLAT = 3'd1,
      FLT_PAGE_XLAT = 3'd2,
      FLT_DOMAIN    = 3'd3,
      FLT_PERM      = 3'd4
   } fault_e;

   // first-level entry kinds (descriptor bits [1:0])
   localparam logic [1:0] L1K_FAULT   = 2'b00;
   localparam logic [1:0] L1K_COARSE  = 2'b01;
   localparam logic [1:0] L1K_SECTION = 2'b10;
   localparam logic [1:0] L1K_FINE    = 2'b11;

   // second-level entry kinds
   localparam logic [1:0] L2K_FAULT = 2'b00;
   localparam logic [1:0] L2K_LARGE = 2'b01;
   localparam logic [1:0] L2K_SMALL = 2'b10;
   localparam logic [1:0] L2K_TINY  = 2'b11;

   // domain modes
   localparam logic [1:0] DM_NONE    = 2'b00;
   localparam logic [1:0] DM_CLIENT  = 2'b01;
   localparam logic [1:0] DM_RSVD    = 2'b10;
   localparam logic [1:0] DM_MANAGER = 2'b11;

endpackage

// File: rtl/walk_l1_decode.sv
module walk_l1_decode #(
   parameter int ADDR_W = 32,
   parameter int DOM_W  = 4
) (
   input  logic [ADDR_W-1:0] va,
   input  logic [ADDR_W-15:0] base,
   input  logic [31:0]       desc,
   output logic [ADDR_W-1:0] l1_addr,
   output logic [1:0]        kind,
   output logic [ADDR_W-1:0] l2_addr,
   output logic [DOM_W-1:0]  dom,
   output logic [ADDR_W-1:0] sec_pa,
   output logic [1:0]        sec_ap,
   output logic              sec_c,
   output logic              sec_b
);
   logic unused_bits;

   assign l1_addr = {base, va[31:20], 2'b00};
   assign kind    = desc[1:0];
   assign dom     = desc[8:5];
   assign l2_addr = (desc[1:0] == walk_pkg::L1K_FINE) ? {desc[31:12], va[19:10], 2'b00}
                                                      : {desc[31:10], va[19:12], 2'b00};
   assign sec_pa  = {desc[31:20], va[19:0]};
   assign sec_ap  = desc[11:10];
   assign sec_c   = desc[3];
   assign sec_b   = desc[2];
   assign unused_bits = ^{desc[9], desc[4]};
endmodule

// File: rtl/walk_l2_decode.sv
module walk_l2_decode #(
   parameter int ADDR_W   = 32,
   parameter int SUBPAGES = 4
) (
   input  logic [15:0]       va_lo,
   input  logic              fine,
   input  logic [31:0]       desc,
   output logic              ok,
   output logic [ADDR_W-1:0] pa,
   output logic [1:0]        ap,
   output logic              c,
   output logic              b
);
   import walk_pkg::*;
   localparam int SEL_W = $clog2(SUBPAGES);

   logic [1:0]       sub_ap [SUBPAGES];
   logic [SEL_W-1:0] sel;

   for (genvar k = 0; k < SUBPAGES; k++) begin : g_sub
      assign sub_ap[k] = desc[4+2*k +: 2];
   end

   always_comb begin
      case (desc[1:0])
         L2K_LARGE: begin sel = va_lo[15:14]; pa = {desc[31:16], va_lo};       end
         L2K_SMALL: begin sel = va_lo[11:10]; pa = {desc[31:12], va_lo[11:0]}; end
         default:   begin sel = '0;           pa = {desc[31:10], va_lo[9:0]};  end
      endcase
   end

   assign ok = fine ? (desc[1:0] == L2K_TINY)
                    : (desc[1:0] == L2K_LARGE || desc[1:0] == L2K_SMALL);
   assign ap = sub_ap[sel];
   assign c  = desc[3];
   assign b  = desc[2];
endmodule

// File: rtl/walk_access_check.sv
module walk_access_check #(
   parameter int NUM_DOM = 16,
   parameter int DOM_W   = 4
) (
   input  logic [2*NUM_DOM-1:0] dac,
   input  logic [DOM_W-1:0]     dom,
   input  logic [1:0]           ap,
   input  logic                 user,
   input  logic                 write,
   output walk_pkg::fault_e     fault
);
   import walk_pkg::*;
   logic [1:0] mode;
   logic       perm_ok;

   assign mode = dac[{dom, 1'b0} +: 2];

   always_comb begin
      case (ap)
         2'b00:   perm_ok = !user && !write;
         2'b01:   perm_ok = !user;
         2'b10:   perm_ok = !user || !write;
         default: perm_ok = 1'b1;
      endcase
      case (mode)
         DM_CLIENT:  fault = perm_ok ? FLT_NONE : FLT_PERM;
         DM_MANAGER: fault = FLT_NONE;
         default:    fault = FLT_DOMAIN;
      endcase
   end
endmodule

// File: rtl/mmu_walker.sv
module mmu_walker #(
   parameter int ADDR_W  = 32,
   parameter int NUM_DOM = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_base_we,
   input  logic              cfg_dac_we,
   input  logic [31:0]       cfg_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_va,
   input  logic              req_user,
   input  logic              req_write,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_ack,
   input  logic [31:0]       mem_rd_data,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_pa,
   output logic              rsp_cacheable,
   output logic              rsp_bufferable,
   output logic [2:0]        rsp_fault
);
   import walk_pkg::*;
   localparam int BASE_W = ADDR_W - 14;
   localparam int DAC_W  = 2 * NUM_DOM;
   localparam int DOM_W  = $clog2(NUM_DOM);

   if (ADDR_W != 32) begin : g_bad_addr_w
      $error("mmu_walker: descriptor formats fix ADDR_W at 32");
   end
   if (NUM_DOM != 16) begin : g_bad_num_dom
      $error("mmu_walker: the 4-bit domain field needs NUM_DOM = 16");
   end

   walk_st_e          st_q;
   logic [ADDR_W-1:0] va_q, l2_addr_q, pa_q;
   logic              user_q, write_q, fine_q, c_q, b_q;
   logic [BASE_W-1:0] base_q;
   logic [DAC_W-1:0]  dac_q;
   logic [DOM_W-1:0]  dom_q;
   fault_e            flt_q;

   logic [ADDR_W-1:0] l1_addr, l2_addr, sec_pa, pg_pa;
   logic [1:0]        l1_kind, sec_ap, pg_ap, chk_ap;
   logic [DOM_W-1:0]  l1_dom, chk_dom;
   logic              sec_c, sec_b, pg_ok, pg_c, pg_b;
   fault_e            acc_flt;

   walk_l1_decode #(.ADDR_W(ADDR_W), .DOM_W(DOM_W)) u_l1 (
      .va(va_q), .base(base_q), .desc(mem_rd_data), .l1_addr(l1_addr),
      .kind(l1_kind), .l2_addr(l2_addr), .dom(l1_dom), .sec_pa(sec_pa),
      .sec_ap(sec_ap), .sec_c(sec_c), .sec_b(sec_b));

   walk_l2_decode #(.ADDR_W(ADDR_W), .SUBPAGES(4)) u_l2 (
      .va_lo(va_q[15:0]), .fine(fine_q), .desc(mem_rd_data), .ok(pg_ok),
      .pa(pg_pa), .ap(pg_ap), .c(pg_c), .b(pg_b));

   assign chk_dom = (st_q == ST_L2) ? dom_q : l1_dom;
   assign chk_ap  = (st_q == ST_L2) ? pg_ap : sec_ap;

   walk_access_check #(.NUM_DOM(NUM_DOM), .DOM_W(DOM_W)) u_acc (
      .dac(dac_q), .dom(chk_dom), .ap(chk_ap), .user(user_q),
      .write(write_q), .fault(acc_flt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         va_q      <= '0;
         user_q    <= 1'b0;
         write_q   <= 1'b0;
         base_q    <= '0;
         dac_q     <= '0;
         l2_addr_q <= '0;
         dom_q     <= '0;
         fine_q    <= 1'b0;
         pa_q      <= '0;
         c_q       <= 1'b0;
         b_q       <= 1'b0;
         flt_q     <= FLT_NONE;
      end else begin
         if (cfg_base_we) base_q <= cfg_wdata[31 -: BASE_W];
         if (cfg_dac_we)  dac_q  <= cfg_wdata[DAC_W-1:0];
         case (st_q)
            ST_IDLE: if (req_valid) begin
               va_q    <= req_va;
               user_q  <= req_user;
               write_q <= req_write;
               st_q    <= ST_L1;
            end
            ST_L1: if (mem_rd_ack) begin
               if (l1_kind == L1K_FAULT) begin
                  flt_q <= FLT_SECT_XLAT;
                  pa_q  <= '0;
                  c_q   <= 1'b0;
                  b_q   <= 1'b0;
                  st_q  <= ST_DONE;
               end else if (l1_kind == L1K_SECTION) begin
                  flt_q <= acc_flt;
                  pa_q  <= (acc_flt == FLT_NONE) ? sec_pa : '0;
                  c_q   <= (acc_flt == FLT_NONE) && sec_c;
                  b_q   <= (acc_flt == FLT_NONE) && sec_b;
                  st_q  <= ST_DONE;
               end else begin
                  l2_addr_q <= l2_addr;
                  dom_q     <= l1_dom;
                  fine_q    <= (l1_kind == L1K_FINE);
                  st_q      <= ST_L2;
               end
            end
            ST_L2: if (mem_rd_ack) begin
               flt_q <= pg_ok ? acc_flt : FLT_PAGE_XLAT;
               pa_q  <= (pg_ok && acc_flt == FLT_NONE) ? pg_pa : '0;
               c_q   <= pg_ok && (acc_flt == FLT_NONE) && pg_c;
               b_q   <= pg_ok && (acc_flt == FLT_NONE) && pg_b;
               st_q  <= ST_DONE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready      = (st_q == ST_IDLE);
   assign mem_rd_req     = (st_q == ST_L1) || (st_q == ST_L2);
   assign mem_rd_addr    = (st_q == ST_L2) ? l2_addr_q : l1_addr;
   assign rsp_valid      = (st_q == ST_DONE);
   assign rsp_pa         = pa_q;
   assign rsp_cacheable  = c_q;
   assign rsp_bufferable = b_q;
   assign rsp_fault      = flt_q;

   // ---------------------------------------------------------------- checks
   logic l1_ack;
   assign l1_ack = (st_q == ST_L1) && mem_rd_ack;

   AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr)); // R2
   AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_rd_req && !rsp_valid); // R2
   AST_L1_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      l1_ack && mem_rd_data[1:0] == L1K_FAULT |=> rsp_valid && rsp_fault == FLT_SECT_XLAT); // R3
   AST_SECTION_PA: assert property (@(posedge clk) disable iff (!rst_n)
      l1_ack && mem_rd_data[1:0] == L1K_SECTION
      |=> rsp_valid && (rsp_fault != FLT_NONE || rsp_pa == {$past(mem_rd_data[31:20]), va_q[19:0]})); // R4
   AST_COARSE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      l1_ack && mem_rd_data[1:0] == L1K_COARSE
      |=> mem_rd_req && mem_rd_addr == {$past(mem_rd_data[31:10]), va_q[19:12], 2'b00}); // R5
   AST_FINE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      l1_ack && mem_rd_data[1:0] == L1K_FINE
      |=> mem_rd_req && mem_rd_addr == {$past(mem_rd_data[31:12]), va_q[19:10], 2'b00}); // R6
   AST_L2_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_L2 && mem_rd_ack && mem_rd_data[1:0] == L2K_FAULT
      |=> rsp_valid && rsp_fault == FLT_PAGE_XLAT); // R7
   AST_MANAGER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      l1_ack && mem_rd_data[1:0] == L1K_SECTION && dac_q[{mem_rd_data[8:5], 1'b0} +: 2] == DM_MANAGER
      |=> rsp_fault == FLT_NONE); // R8
   AST_CLIENT_KRO: assert property (@(posedge clk) disable iff (!rst_n)
      l1_ack && mem_rd_data[1:0] == L1K_SECTION && dac_q[{mem_rd_data[8:5], 1'b0} +: 2] == DM_CLIENT
      && mem_rd_data[11:10] == 2'b00 && write_q |=> rsp_fault == FLT_PERM); // R9
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid && req_ready); // R10
   AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault != FLT_NONE |-> rsp_pa == '0 && !rsp_cacheable && !rsp_bufferable); // R10
endmodule

// File: tb/mmu_walker_test.sv
`timescale 1ns/1ps
module mmu_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_base_we = 1'b0, cfg_dac_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0, req_user = 1'b0, req_write = 1'b0;
   logic [31:0] req_va = '0;
   logic        req_ready;
   logic        mem_rd_req, mem_rd_ack = 1'b0;
   logic [31:0] mem_rd_addr, mem_rd_data = '0;
   logic        rsp_valid, rsp_cacheable, rsp_bufferable;
   logic [31:0] rsp_pa;
   logic [2:0]  rsp_fault;

   always #2.5 clk = ~clk;   // 200 MHz

   mmu_walker uut (
      .clk(clk), .rst_n(rst_n), .cfg_base_we(cfg_base_we), .cfg_dac_we(cfg_dac_we),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .req_user(req_user), .req_write(req_write),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
      .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
      .rsp_cacheable(rsp_cacheable), .rsp_bufferable(rsp_bufferable), .rsp_fault(rsp_fault));

   int          n_chk = 0, n_bad = 0;
   logic [31:0] mem [int unsigned];
   logic [31:0] log_addr [4];
   int          log_n = 0;
   logic [17:0] tb_base = '0;
   logic [31:0] tb_dac = '0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   // memory responder: acks a pending read after 0..2 cycles
   initial begin
      int wait_n = 0;
      forever begin
         @(negedge clk);
         mem_rd_ack = 1'b0;
         if (mem_rd_req) begin
            if (wait_n == 0) begin
               mem_rd_ack  = 1'b1;
               mem_rd_data = rd(mem_rd_addr);
               if (log_n < 4) log_addr[log_n] = mem_rd_addr;
               log_n++;
               wait_n = int'($urandom % 3);
            end else wait_n--;
         end
      end
   end

   // ------------------------------------------------ reference model
   function automatic logic [2:0] acc(input logic [3:0] dom, input logic [1:0] ap,
                                      input logic u, input logic w);
      logic [1:0] mode;
      logic       ok;
      mode = tb_dac[2*dom +: 2];
      if (mode == 2'b11) return 3'd0;
      if (mode != 2'b01) return 3'd3;
      case (ap)
         2'b00: ok = !u && !w;
         2'b01: ok = !u;
         2'b10: ok = !u || !w;
         default: ok = 1'b1;
      endcase
      return ok ? 3'd0 : 3'd4;
   endfunction

   function automatic logic [31:0] l1a(input logic [31:0] va);
      return {tb_base, va[31:20], 2'b00};
   endfunction

   function automatic logic [31:0] l2a(input logic [31:0] va, input logic [31:0] d1);
      return (d1[1:0] == 2'b11) ? {d1[31:12], va[19:10], 2'b00} : {d1[31:10], va[19:12], 2'b00};
   endfunction

   function automatic void model(input logic [31:0] va, input logic u, input logic w,
                                 output logic [31:0] pa, output logic [1:0] cb,
                                 output logic [2:0] flt, output int nrd,
                                 output logic [31:0] a2, output int gr);
      logic [31:0] d1, d2;
      logic [1:0]  ap;
      int          sel;
      d1 = rd(l1a(va));
      nrd = 1; pa = '0; cb = '0; a2 = '0; gr = 0; flt = 3'd0;
      if (d1[1:0] == 2'b00) flt = 3'd1;
      else if (d1[1:0] == 2'b10) begin
         flt = acc(d1[8:5], d1[11:10], u, w);
         if (flt == 0) begin pa = {d1[31:20], va[19:0]}; cb = d1[3:2]; end
      end else begin
         nrd = 2;
         a2 = l2a(va, d1);
         d2 = rd(a2);
         gr = (d1[1:0] == 2'b11) ? 2 : 1;
         if ((gr == 2 && d2[1:0] != 2'b11) || (gr == 1 && (d2[1:0] == 2'b00 || d2[1:0] == 2'b11)))
            flt = 3'd2;
         else begin
            sel = (d2[1:0] == 2'b01) ? int'(va[15:14]) : (d2[1:0] == 2'b10) ? int'(va[11:10]) : 0;
            ap  = d2[4+2*sel +: 2];
            flt = acc(d1[8:5], ap, u, w);
            if (flt == 0) begin
               cb = d2[3:2];
               if (d2[1:0] == 2'b01)      pa = {d2[31:16], va[15:0]};
               else if (d2[1:0] == 2'b10) pa = {d2[31:12], va[11:0]};
               else                       pa = {d2[31:10], va[9:0]};
            end
         end
      end
   endfunction

   // ------------------------------------------------ drivers
   task automatic set_base(input logic [31:0] v);
      @(negedge clk); cfg_base_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_base_we = 1'b0;
      tb_base = v[31:14];
   endtask

   task automatic set_dac(input logic [31:0] v);
      @(negedge clk); cfg_dac_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_dac_we = 1'b0;
      tb_dac = v;
   endtask

   task automatic set_walk(input logic [31:0] va, input logic [31:0] d1, input logic [31:0] d2);
      mem[l1a(va)] = d1;
      if (d1[0]) mem[l2a(va, d1)] = d2;
   endtask

   task automatic xlat(input logic [31:0] va, input logic u, input logic w,
                       input string tag_in, input bit hold);
      logic [31:0] pa, a2;
      logic [1:0]  cb;
      logic [2:0]  flt;
      int          nrd, gr, cyc;
      string       tag;
      model(va, u, w, pa, cb, flt, nrd, a2, gr);
      if (tag_in != "") tag = tag_in;
      else case (flt)
         3'd1: tag = "R3";
         3'd2: tag = "R7";
         3'd3: tag = "R8";
         3'd4: tag = "R9";
         default: tag = (gr == 0) ? "R4" : (gr == 1) ? "R5" : "R6";
      endcase
      log_n = 0;
      @(negedge clk);
      req_valid = 1'b1; req_va = va; req_user = u; req_write = w;
      @(negedge clk);
      if (hold) begin req_va = ~va; req_user = ~u; req_write = ~w; end
      else req_valid = 1'b0;
      cyc = 0;
      while (!rsp_valid && cyc < 100) begin @(negedge clk); cyc++; end
      req_valid = 1'b0;
      chk(rsp_valid, tag, "response arrives", {31'b0, rsp_valid}, 32'h1);
      chk(rsp_fault == flt, tag, "fault code", {29'b0, rsp_fault}, {29'b0, flt});
      chk(rsp_pa == pa, tag, "physical address", rsp_pa, pa);
      chk({rsp_cacheable, rsp_bufferable} == cb, tag, "cacheable/bufferable",
          {30'b0, rsp_cacheable, rsp_bufferable}, {30'b0, cb});
      chk(log_n == nrd, (nrd == 1) ? "R3" : tag, "read count", log_n, nrd);
      chk(log_addr[0] == l1a(va), "R2", "first-level address", log_addr[0], l1a(va));
      if (nrd == 2)
         chk(log_addr[1] == a2, (gr == 2) ? "R6" : "R5", "second-level address", log_addr[1], a2);
      @(negedge clk);
      chk(!rsp_valid && req_ready, "R10", "single-cycle response",
          {30'b0, rsp_valid, req_ready}, 32'h1);
   endtask

   function automatic logic [31:0] sec_d(input logic [11:0] pa12, input logic [1:0] ap,
                                         input logic [3:0] dom, input logic c, input logic b);
      return {pa12, 8'h00, ap, 1'b0, dom, 1'b0, c, b, 2'b10};
   endfunction

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(req_ready && !mem_rd_req && !rsp_valid, "R1", "reset outputs",
          {29'b0, req_ready, mem_rd_req, rsp_valid}, 32'h4);
      rst_n = 1'b1;
      set_base(32'h0000_8000);
      set_dac(32'h5555_5587);   // d0 manager, d1 client, d2 none, d3 reserved, rest client

      // R3 first-level fault
      set_walk(32'h0011_2345, 32'h0, 32'h0);
      xlat(32'h0011_2345, 1'b1, 1'b0, "R3", 1'b0);
      // R4 / R8 manager section, user write on kernel read-only bits
      set_walk(32'h0021_2345, sec_d(12'hABC, 2'b00, 4'd0, 1'b1, 1'b0), 32'h0);
      xlat(32'h0021_2345, 1'b1, 1'b1, "R8", 1'b0);
      xlat(32'h0021_2345, 1'b0, 1'b0, "R4", 1'b0);
      // R9 every permission value under a client domain
      for (int ap = 0; ap < 4; ap++) begin
         set_walk(32'h0030_0000 + ap * 32'h0010_0000 + 32'h0000_0F0F,
                  sec_d(12'h123 + 12'(ap), 2'(ap), 4'd1, 1'b0, 1'b1), 32'h0);
         for (int k = 0; k < 4; k++)
            xlat(32'h0030_0000 + ap * 32'h0010_0000 + 32'h0000_0F0F, k[1], k[0], "R9", 1'b0);
      end
      // R8 no-access and reserved domains win over open permissions
      set_walk(32'h0070_0000, sec_d(12'h777, 2'b11, 4'd2, 1'b1, 1'b1), 32'h0);
      xlat(32'h0070_0000, 1'b0, 1'b0, "R8", 1'b0);
      set_walk(32'h0080_0000, sec_d(12'h888, 2'b11, 4'd3, 1'b1, 1'b1), 32'h0);
      xlat(32'h0080_0000, 1'b0, 1'b0, "R8", 1'b0);
      // R5 large page, each quarter with its own permission (0,1,2,3)
      for (int q = 0; q < 4; q++) begin
         logic [31:0] va;
         va = {12'h090, 4'h5, 2'(q), 14'h1234};
         set_walk(va, {22'h200040, 1'b0, 4'd1, 3'b0, 2'b01},
                  {16'hBEEF, 4'h0, 2'b11, 2'b10, 2'b01, 2'b00, 2'b11, 2'b01});
         xlat(va, 1'b1, 1'b0, "R5", 1'b0);
         xlat(va, 1'b0, 1'b1, "R5", 1'b0);
      end
      // R5 small page quarter select by VA[11:10]
      for (int q = 0; q < 4; q++) begin
         logic [31:0] va;
         va = {12'h0A0, 8'h33, 2'(q), 10'h155};
         set_walk(va, {22'h200080, 1'b0, 4'd1, 3'b0, 2'b01},
                  {20'hCAFE1, 2'b00, 2'b01, 2'b10, 2'b11, 2'b10, 2'b10});
         xlat(va, 1'b1, 1'b1, "R5", 1'b0);
      end
      // R6 tiny page in a fine table
      set_walk(32'h00B4_5678, {20'h80012, 3'b0, 4'd1, 3'b0, 2'b11},
               {22'h1ABCDE, 4'h0, 2'b10, 2'b11, 2'b11});
      xlat(32'h00B4_5678, 1'b1, 1'b0, "R6", 1'b0);
      xlat(32'h00B4_5678, 1'b1, 1'b1, "R6", 1'b0);
      // R7 page translation faults
      set_walk(32'h00C0_1000, {22'h2000C0, 1'b0, 4'd0, 3'b0, 2'b01}, 32'hFFFF_F000);
      xlat(32'h00C0_1000, 1'b0, 1'b0, "R7", 1'b0);
      set_walk(32'h00D0_2000, {22'h200100, 1'b0, 4'd0, 3'b0, 2'b01}, 32'hFFFF_FFF3);
      xlat(32'h00D0_2000, 1'b0, 1'b0, "R7", 1'b0);
      set_walk(32'h00E0_3000, {20'h80020, 3'b0, 4'd0, 3'b0, 2'b11}, 32'hFFFF_FFF2);
      xlat(32'h00E0_3000, 1'b0, 1'b0, "R7", 1'b0);
      // R2 request inputs held and changed during a walk have no effect
      xlat(32'h00B4_5678, 1'b1, 1'b0, "R2", 1'b1);
      xlat(32'h0021_2345, 1'b0, 1'b0, "R2", 1'b1);
      // R11 new base and domain register
      set_base(32'h0004_FFFF);
      set_dac(32'hFFFF_FFFD);   // domain 0 client, others manager
      set_walk(32'h0021_2345, sec_d(12'h5A5, 2'b01, 4'd0, 1'b1, 1'b1), 32'h0);
      xlat(32'h0021_2345, 1'b1, 1'b0, "R11", 1'b0);
      xlat(32'h0021_2345, 1'b0, 1'b1, "R11", 1'b0);

      // constrained random walks
      set_base(32'h0001_C000);
      for (int i = 0; i < 300; i++) begin
         logic [31:0] va, d1, d2;
         if (i % 25 == 0) set_dac($urandom);
         va = $urandom;
         d1 = $urandom;
         if (d1[0]) d1[31] = 1'b1;
         if ($urandom % 8 == 0) d1[1:0] = 2'b00;
         d2 = $urandom;
         set_walk(va, d1, d2);
         xlat(va, 1'($urandom), 1'($urandom), "", 1'b0);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule